// File: doc/BRIEF.md
# MAC Error Flag Register with Interrupt Routing

This block holds the sticky error flags of a network controller's MAC: transmit overrun (babble), collision-test failure, missed receive frame and memory error. Each flag is set by a hardware condition and stays set until software writes a 1 to its bit. A read-only summary bit is high whenever any flag is set. A registered interrupt request combines a global enable with per-flag masks. The collision-test flag is never routed to the interrupt.

Two of the set conditions are detected inside the block. A transmit length guard counts byte strobes from each frame start and flags babble when a frame reaches 1519 bytes. A collision-test watcher starts a window at each frame end. If the collision-test input stays low for 20 bit-time ticks, the watcher flags a collision error. The missed-frame and memory-error flags come straight from MAC event pulses. There is no streaming data path: every pin is a plain control or status signal, sampled on the rising clock edge.

Top module: `mac_err_status`

## Requirements
- R1: Hardware reset (`rst_n` low, asynchronous) and software reset (`soft_rst` high, synchronous) clear all flags, the interrupt request, the byte counter and the collision-test window.
- R2: Flag bit 0 (babble) sets on the clock edge that takes the 1519th `tx_byte` strobe since the last `tx_sof`. A `tx_sof` restarts the count, and a byte strobed in the same cycle counts as byte 1. A frame of 1518 bytes does not set it.
- R3: The byte count saturates, so babble is raised at most once per frame. If software clears the flag while the same frame keeps sending bytes, the flag stays clear.
- R4: Flag bit 1 (collision error) sets one cycle after the 20th `bit_tick` that follows a `tx_eof`, provided `sqe_in` was not seen in the window. `sqe_in` high in any cycle of the window cancels it, including the cycle of the 20th tick. A new `tx_eof` restarts the window.
- R5: Flag bit 2 (missed frame) sets on the edge after an `ev_miss` pulse. Flag bit 3 (memory error) sets on the edge after an `ev_merr` pulse.
- R6: When `wr_en` is high, each 1 in `wr_data[3:0]` clears the matching flag and each 0 leaves it unchanged. If a set event and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: `err_sum` is the combinational OR of the four flags. It cannot be written.
- R8: `irq` is registered. One cycle after the flags change, `irq` equals `int_en` AND any of: (babble AND NOT `irq_mask[0]`), (missed AND NOT `irq_mask[1]`), (memory AND NOT `irq_mask[2]`).
- R9: The collision-error flag never asserts `irq`, whatever the enable and mask values.
- R10: While `stop` is high, all flags and `irq` are cleared on each edge. The byte counter and the collision-test window are also reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| stop | input | 1 | Stop control; clears flags while high |
| tx_sof | input | 1 | Transmit frame start marker |
| tx_byte | input | 1 | One transmitted byte per high cycle |
| tx_eof | input | 1 | Transmit frame end marker; opens the collision-test window |
| bit_tick | input | 1 | One network bit time elapsed |
| sqe_in | input | 1 | Collision-test response from the transceiver |
| ev_miss | input | 1 | Receive frame dropped, no descriptor |
| ev_merr | input | 1 | Memory access error pulse |
| wr_en | input | 1 | Host write strobe for flag clears |
| wr_data | input | 4 | Write-one-to-clear mask, bit order as the flags |
| int_en | input | 1 | Global interrupt enable |
| irq_mask | input | 3 | Interrupt masks: [0] babble, [1] missed, [2] memory |
| flags | output | 4 | [0] babble, [1] collision error, [2] missed, [3] memory |
| err_sum | output | 1 | OR of all flags |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situations to reach from the ports are the two counted windows. For babble, the stimulus streams exactly 1518 bytes in one frame and then exactly 1519 bytes in the next. It then clears the flag mid-frame and keeps sending bytes, to show saturation. For the collision test, the stimulus places `sqe_in` on the very cycle of the 20th tick, and also inside a window that a second `tx_eof` has just restarted. A behavioural reference model in the bench tracks these counts and is compared with every output on every clock.

// File: rtl/err_pkg.sv
package err_pkg;
  localparam int NFLAG    = 4;
  localparam int IDX_BABL = 0;
  localparam int IDX_COLL = 1;
  localparam int IDX_MISS = 2;
  localparam int IDX_MEM  = 3;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/tx_len_guard.sv
module tx_len_guard #(
  parameter int LIMIT = 1519
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sof,
  input  logic bstb,
  output logic over
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_comb begin
    if (sof) over = bstb && (LIMIT == 1);
    else     over = bstb && (cnt == W'(LIMIT - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (clr)                        cnt <= '0;
    else if (sof)                        cnt <= bstb ? W'(1) : '0;
    else if (bstb && cnt != W'(LIMIT))   cnt <= cnt + W'(1);
  end

  // R3
  once_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (over && !clr && !sof) |=> !over || sof);
endmodule

// File: rtl/sqe_watch.sv
module sqe_watch #(
  parameter int WIN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic eof,
  input  logic tick,
  input  logic sqe,
  output logic fail
);
  localparam int W = $clog2(WIN + 1);
  logic [W-1:0] cnt;
  logic         armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; cnt <= '0; fail <= 1'b0;
    end else if (clr) begin
      armed <= 1'b0; cnt <= '0; fail <= 1'b0;
    end else begin
      fail <= 1'b0;
      if (eof) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed) begin
        if (sqe) armed <= 1'b0;
        else if (tick) begin
          if (cnt == W'(WIN - 1)) begin
            fail  <= 1'b1;
            armed <= 1'b0;
          end else cnt <= cnt + W'(1);
        end
      end
    end
  end

  // R4
  sqe_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sqe && !eof) |=> !fail);
  // R4
  fail_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);
endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import err_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  flag_vec_t ev,
  input  logic      wr,
  input  flag_vec_t wdat,
  output flag_vec_t flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             flags[i] <= 1'b0;
      else if (clr)           flags[i] <= 1'b0;
      else if (ev[i])         flags[i] <= 1'b1;
      else if (wr && wdat[i]) flags[i] <= 1'b0;
    end
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ev != '0) |=> ((flags & $past(ev)) == $past(ev)));
  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> ((flags & $past(wdat & ~ev)) == '0));
  // R10
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags == '0));
endmodule

// File: rtl/mac_err_status.sv
module mac_err_status
  import err_pkg::*;
#(
  parameter int BABL_LIMIT = 1519,
  parameter int SQE_WIN    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       stop,
  input  logic       tx_sof,
  input  logic       tx_byte,
  input  logic       tx_eof,
  input  logic       bit_tick,
  input  logic       sqe_in,
  input  logic       ev_miss,
  input  logic       ev_merr,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  input  logic       int_en,
  input  logic [2:0] irq_mask,
  output logic [3:0] flags,
  output logic       err_sum,
  output logic       irq
);
  logic      halt;
  logic      babl_ev;
  logic      coll_ev;
  flag_vec_t ev;
  flag_vec_t route;
  flag_vec_t fl;

  assign halt = soft_rst | stop;

  tx_len_guard #(.LIMIT(BABL_LIMIT)) u_len (
    .clk(clk), .rst_n(rst_n), .clr(halt),
    .sof(tx_sof), .bstb(tx_byte), .over(babl_ev)
  );

  sqe_watch #(.WIN(SQE_WIN)) u_sqe (
    .clk(clk), .rst_n(rst_n), .clr(halt),
    .eof(tx_eof), .tick(bit_tick), .sqe(sqe_in), .fail(coll_ev)
  );

  always_comb begin
    ev           = '0;
    ev[IDX_BABL] = babl_ev;
    ev[IDX_COLL] = coll_ev;
    ev[IDX_MISS] = ev_miss;
    ev[IDX_MEM]  = ev_merr;
    route           = '0;
    route[IDX_BABL] = ~irq_mask[0];
    route[IDX_MISS] = ~irq_mask[1];
    route[IDX_MEM]  = ~irq_mask[2];
  end

  flag_bank u_bank (
    .clk(clk), .rst_n(rst_n), .clr(halt),
    .ev(ev), .wr(wr_en), .wdat(wr_data), .flags(fl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    irq <= 1'b0;
    else if (halt) irq <= 1'b0;
    else           irq <= int_en && ((fl & route) != '0);
  end

  assign flags   = fl;
  assign err_sum = |fl;

  // R9
  coll_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl == 4'b0010) |=> !irq);
  // R8
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |=> !irq);
endmodule

// File: tb/sim_mac_err_status.sv
module sim_mac_err_status;
  localparam int LIM = 1519;
  localparam int WIN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, stop = 0, tx_sof = 0, tx_byte = 0, tx_eof = 0;
  logic bit_tick = 0, sqe_in = 0, ev_miss = 0, ev_merr = 0, wr_en = 0;
  logic [3:0] wr_data = '0;
  logic int_en = 0;
  logic [2:0] irq_mask = '0;
  logic [3:0] flags;
  logic err_sum, irq;

  mac_err_status u0 (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  string phase = "R1";
  bit done = 0;

  // reference model state
  int m_cnt = 0, m_win = 0;
  bit m_armed = 0, m_fail = 0, m_irq = 0;
  bit [3:0] m_flags = '0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (phase %s) t=%0t actual=%0d expected=%0d", req, phase, $time, act, exp);
    end
  endtask

  task automatic model_edge();
    bit bev;
    bit [3:0] ev, route;
    if (!rst_n || soft_rst || stop) begin
      m_cnt = 0; m_win = 0; m_armed = 0; m_fail = 0; m_irq = 0; m_flags = '0;
      return;
    end
    bev = tx_byte && (tx_sof ? (LIM == 1) : (m_cnt == LIM - 1));
    ev = {ev_merr, ev_miss, m_fail, bev};
    route = {~irq_mask[2], ~irq_mask[1], 1'b0, ~irq_mask[0]};
    m_irq = int_en && ((m_flags & route) != 0);
    m_flags = (m_flags & ~(wr_en ? wr_data : 4'b0)) | ev;
    if (tx_sof) m_cnt = tx_byte ? 1 : 0;
    else if (tx_byte && m_cnt < LIM) m_cnt++;
    m_fail = 0;
    if (tx_eof) begin m_armed = 1; m_win = 0; end
    else if (m_armed) begin
      if (sqe_in) m_armed = 0;
      else if (bit_tick) begin
        if (m_win == WIN - 1) begin m_fail = 1; m_armed = 0; end
        else m_win++;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R2", flags[0], m_flags[0]);
    check("R4", flags[1], m_flags[1]);
    check("R5", flags[3:2], m_flags[3:2]);
    check("R7", err_sum, |m_flags);
    check("R8", irq, m_irq);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = 4'hF; step(); wr_en = 0; wr_data = 0;
  endtask

  initial begin
    @(negedge clk);
    idle(2);
    // R1: reset state
    check("R1", flags, 0); check("R1", irq, 0);
    rst_n = 1;
    idle(2);

    // R5: event pulses; R7 summary; R8 interrupt
    phase = "R5";
    int_en = 1;
    ev_miss = 1; step(); ev_miss = 0; idle(2);
    check("R8", irq, 1);
    ev_merr = 1; step(); ev_merr = 0; idle(1);
    check("R5", flags, 4'b1100);

    // R6: write zero does nothing, write one clears, set wins
    phase = "R6";
    wr_en = 1; wr_data = 4'h0; step(); wr_en = 0;
    check("R6", flags, 4'b1100);
    wr_en = 1; wr_data = 4'b0100; step(); wr_en = 0;
    check("R6", flags, 4'b1000);
    wr_en = 1; wr_data = 4'b1000; ev_merr = 1; step(); wr_en = 0; ev_merr = 0;
    check("R6", flags, 4'b1000);
    clear_all(); idle(2);

    // R8: masks
    phase = "R8";
    irq_mask = 3'b010; ev_miss = 1; step(); ev_miss = 0; idle(2);
    check("R8", irq, 0);
    irq_mask = 3'b000; idle(2);
    check("R8", irq, 1);
    int_en = 0; idle(2);
    check("R8", irq, 0);
    int_en = 1; clear_all(); idle(2);

    // R2: 1518-byte frame, then 1519-byte frame
    phase = "R2";
    tx_sof = 1; tx_byte = 1; step(); tx_sof = 0;
    idle(LIM - 2); tx_byte = 0; idle(2);
    check("R2", flags[0], 0);
    tx_sof = 1; tx_byte = 1; step(); tx_sof = 0;
    idle(LIM - 1); tx_byte = 0; idle(2);
    check("R2", flags[0], 1);
    check("R8", irq, 1);

    // R3: clear mid-frame, keep sending, flag stays clear
    phase = "R3";
    clear_all();
    tx_byte = 1; idle(100); tx_byte = 0; idle(2);
    check("R3", flags[0], 0);

    // R4: window expires, collision flag set
    phase = "R4";
    tx_eof = 1; step(); tx_eof = 0;
    for (int i = 0; i < WIN; i++) begin bit_tick = 1; step(); bit_tick = 0; step(); end
    idle(2);
    check("R4", flags[1], 1);
    // R9: only collision set -> no interrupt
    phase = "R9";
    idle(2);
    check("R9", irq, 0);
    clear_all();
    // R4: sqe on the 20th tick cancels
    phase = "R4";
    tx_eof = 1; step(); tx_eof = 0;
    for (int i = 0; i < WIN; i++) begin
      bit_tick = 1; sqe_in = (i == WIN - 1); step(); bit_tick = 0; sqe_in = 0; step();
    end
    idle(4);
    check("R4", flags[1], 0);
    // R4: restart by second eof, then sqe
    tx_eof = 1; step(); tx_eof = 0;
    for (int i = 0; i < 15; i++) begin bit_tick = 1; step(); bit_tick = 0; end
    tx_eof = 1; step(); tx_eof = 0;
    for (int i = 0; i < 15; i++) begin bit_tick = 1; step(); bit_tick = 0; end
    sqe_in = 1; step(); sqe_in = 0;
    for (int i = 0; i < 10; i++) begin bit_tick = 1; step(); bit_tick = 0; end
    idle(2);
    check("R4", flags[1], 0);

    // R10: stop clears and holds clear
    phase = "R10";
    ev_miss = 1; ev_merr = 1; step(); ev_miss = 0; ev_merr = 0; idle(1);
    stop = 1; step();
    check("R10", flags, 0);
    ev_miss = 1; step(); ev_miss = 0; step();
    check("R10", flags, 0); check("R10", irq, 0);
    stop = 0; idle(2);

    // R1: software reset
    phase = "R1";
    ev_merr = 1; step(); ev_merr = 0; idle(1);
    soft_rst = 1; step(); soft_rst = 0;
    check("R1", flags, 0); check("R1", irq, 0);
    idle(3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (phase %s) actual=running expected=finished", phase);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule